// File: doc/BRIEF.md
# Reset Cause and Soft-Reset Control Register

This block holds a single 32-bit register that remembers why the system last came out of reset and lets software ask for a new reset. Five cause and control flags sit in the top five bits of the word, and every other bit reads as zero. Three of the flags are sticky status that software clears by writing ones. The other two are plain read/write control bits. Writing either of those two bits to one also raises a one-cycle reset request toward the external reset sequencer.

The sequencer reports each system reset it performs back to this block as a single-cycle event. A saturating event counter survives those system resets and is cleared only by the power-up reset or by a soft power-on request. When a system reset arrives while the counter is zero, the register is reloaded with only the power-on flag set. Any later reset leaves the register as it was.

The register sits in an 8-byte window. Only offsets with address bit 2 set reach it. Reads return data one cycle after the request.

Top module: `reset_cause_reg`

## Requirements
- R1: Bit 31 is the power-on flag, bit 30 the soft power-on request, bit 29 the soft external-reset request, bit 28 the button power-on flag and bit 27 the button external-reset flag. Bits 26..0 always read as zero, whatever was written.
- R2: A write of one to bit 31, 28 or 27 clears that bit. A write of zero to any of these bits leaves it unchanged, and none of them can be set by a write.
- R3: Bits 30 and 29 take the written value on every accepted write.
- R4: An accepted write with bit 30 set raises `rst_req_o` for exactly one cycle, starting the cycle after the write, and zeroes the event counter. The next system reset is then treated as power-on, even if the counter had saturated.
- R5: An accepted write with bit 29 set and bit 30 clear raises the same one-cycle request but keeps the event counter.
- R6: A `sys_rst_i` event while the counter is zero loads the register with 0x80000000. An event while the counter is nonzero leaves the register unchanged.
- R7: The counter adds one on each `sys_rst_i` event and stops at its maximum (2^CNT_W - 1) instead of wrapping back to zero.
- R8: Reads and writes reach the register only when `addr[2]` is 1. Other offsets read as zero, and writes to them change nothing and raise no request.
- R9: If a write arrives in the same cycle as a `sys_rst_i` event, the write is dropped and no request is raised.
- R10: While `rst` is high, the register, the counter, `rst_req_o` and `rd_data` are all cleared.
- R11: `rd_data` shows the addressed value in the cycle after `rd_en`, and is zero when no read is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| sys_rst_i | input | 1 | One-cycle event marking each system reset that was carried out |
| addr | input | ADDR_W | Byte offset within the register window |
| wr_en | input | 1 | Write strobe |
| wr_data | input | WORD_W | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | WORD_W | Registered read data |
| rst_req_o | output | 1 | One-cycle system reset request |

## Verification
The bench aims at three mixed-access cases:
- Clearing a set sticky flag while rewriting a control bit in the same word. A design that treated the whole word as write-one-to-clear, or as plain write, would read back the wrong pattern.
- The counter boundaries. Twenty resets past the first must leave a cleared power-on flag cleared; a counter that wrapped would set it again on the sixteenth. A soft power-on request made after saturation must still give the power-on pattern on the next reset.
- Collisions and misses. A write that meets a reset event in the same cycle, and writes to offsets with address bit 2 clear, must leave both the register and the request line unchanged.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  localparam int WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;

  localparam int BIT_PWRON     = WORD_W - 1;
  localparam int BIT_SW_PWRON  = WORD_W - 2;
  localparam int BIT_SW_EXT    = WORD_W - 3;
  localparam int BIT_BTN_PWRON = WORD_W - 4;
  localparam int BIT_BTN_EXT   = WORD_W - 5;

  localparam word_t PWRON_ONLY = word_t'(1) << BIT_PWRON;
  localparam word_t STICKY_MASK = (word_t'(1) << BIT_PWRON)
                                | (word_t'(1) << BIT_BTN_PWRON)
                                | (word_t'(1) << BIT_BTN_EXT);
  localparam word_t DIRECT_MASK = (word_t'(1) << BIT_SW_PWRON)
                                | (word_t'(1) << BIT_SW_EXT);
  localparam word_t LIVE_MASK = STICKY_MASK | DIRECT_MASK;
endpackage

// File: rtl/rsc_decode.sv
module rsc_decode #(
  parameter int ADDR_W  = 3,
  parameter int SEL_BIT = 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              sys_rst_i,
  output logic              wr_hit,
  output logic              rd_hit
);
  logic unused_addr_bits;
  assign unused_addr_bits = &{1'b0, addr};

  // A reset event takes the cycle; a colliding write is dropped.
  assign wr_hit = wr_en && addr[SEL_BIT] && !sys_rst_i;
  assign rd_hit = rd_en && addr[SEL_BIT];
endmodule

// File: rtl/rsc_event_cnt.sv
module rsc_event_cnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt_q,
  output logic             first
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (evt) begin
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end else if (clr) begin
      cnt_q <= '0;
    end
  end

  assign first = (cnt_q == '0);
endmodule

// File: rtl/rsc_status.sv
module rsc_status
  import rsc_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  evt,
  input  logic  first,
  input  logic  wr_hit,
  input  word_t wr_data,
  output word_t status_q,
  output logic  req_q,
  output logic  clr_cnt
);
  word_t wv;
  word_t next_wr;

  assign wv      = wr_data & LIVE_MASK;
  assign next_wr = (status_q & ~(wv & STICKY_MASK) & ~DIRECT_MASK)
                 | (wv & DIRECT_MASK);
  assign clr_cnt = wr_hit && wv[BIT_SW_PWRON];

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      req_q    <= 1'b0;
    end else begin
      req_q <= 1'b0;
      if (evt) begin
        if (first) status_q <= PWRON_ONLY;
      end else if (wr_hit) begin
        status_q <= next_wr;
        req_q    <= |(wv & DIRECT_MASK);
      end
    end
  end
endmodule

// File: rtl/reset_cause_reg.sv
module reset_cause_reg
  import rsc_pkg::*;
#(
  parameter int ADDR_W  = 3,
  parameter int SEL_BIT = 2,
  parameter int CNT_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sys_rst_i,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [WORD_W-1:0] rd_data,
  output logic              rst_req_o
);
  logic             wr_hit, rd_hit, first, clr_cnt;
  logic [CNT_W-1:0] cnt_q;
  word_t            status_q;

  rsc_decode #(.ADDR_W(ADDR_W), .SEL_BIT(SEL_BIT)) u_dec (
    .addr(addr), .wr_en(wr_en), .rd_en(rd_en), .sys_rst_i(sys_rst_i),
    .wr_hit(wr_hit), .rd_hit(rd_hit)
  );

  rsc_event_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .evt(sys_rst_i), .clr(clr_cnt),
    .cnt_q(cnt_q), .first(first)
  );

  rsc_status u_stat (
    .clk(clk), .rst(rst), .evt(sys_rst_i), .first(first),
    .wr_hit(wr_hit), .wr_data(wr_data),
    .status_q(status_q), .req_q(rst_req_o), .clr_cnt(clr_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_hit ? status_q : '0;
  end
endmodule

// File: rtl/rsc_checker.sv
module rsc_checker
  import rsc_pkg::*;
#(
  parameter int ADDR_W  = 3,
  parameter int SEL_BIT = 2,
  parameter int CNT_W   = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              sys_rst_i,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [WORD_W-1:0] wr_data,
  input logic [WORD_W-1:0] rd_data,
  input logic              rst_req_o,
  input logic [WORD_W-1:0] status_q,
  input logic [CNT_W-1:0]  cnt_q
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  AST_DEAD_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_data & ~LIVE_MASK) == '0); // R1

  AST_REQ_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
    rst_req_o |-> $past(wr_en && addr[SEL_BIT] && !sys_rst_i
                        && (wr_data[BIT_SW_PWRON] || wr_data[BIT_SW_EXT]))); // R5

  AST_FIRST_LOADS_PWRON: assert property (@(posedge clk) disable iff (rst)
    (sys_rst_i && cnt_q == '0) |=> status_q == PWRON_ONLY); // R6

  AST_LATER_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (sys_rst_i && cnt_q != '0) |=> $stable(status_q)); // R6

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (sys_rst_i && cnt_q == CMAX) |=> cnt_q == CMAX); // R7

  AST_MISS_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !addr[SEL_BIT] && !sys_rst_i) |=> ($stable(status_q) && !rst_req_o)); // R8

  AST_COLLIDE_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    sys_rst_i |=> !rst_req_o); // R9
endmodule

bind reset_cause_reg rsc_checker #(.ADDR_W(ADDR_W), .SEL_BIT(SEL_BIT), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .sys_rst_i(sys_rst_i), .addr(addr), .wr_en(wr_en),
  .wr_data(wr_data), .rd_data(rd_data), .rst_req_o(rst_req_o),
  .status_q(status_q), .cnt_q(cnt_q)
);

// File: tb/test_reset_cause_reg.sv
`timescale 1ns/100ps
module test_reset_cause_reg;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sys_rst_i = 1'b0;
  logic [2:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic        rst_req_o;

  int checks = 0;
  int failures = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  reset_cause_reg i_reset_cause_reg (
    .clk(clk), .rst(rst), .sys_rst_i(sys_rst_i), .addr(addr),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .rst_req_o(rst_req_o)
  );

  typedef struct packed {
    logic [2:0]  a;
    logic [31:0] d;
    logic [31:0] exp;
    logic        req;
  } vec_t;

  // Walked from state 0x80000000 with counter 1.
  localparam vec_t VEC [7] = '{
    '{3'd4, 32'h2000_0000, 32'hA000_0000, 1'b1},  // R3 R5 soft external request
    '{3'd0, 32'hFFFF_FFFF, 32'hA000_0000, 1'b0},  // R8 offset miss
    '{3'd4, 32'h8000_0000, 32'h0000_0000, 1'b0},  // R2 clear flag, R3 bit29 rewritten 0
    '{3'd4, 32'h1800_0000, 32'h0000_0000, 1'b0},  // R2 ones never set sticky bits
    '{3'd4, 32'h07FF_FFFF, 32'h0000_0000, 1'b0},  // R1 dead bits
    '{3'd3, 32'h4000_0000, 32'h0000_0000, 1'b0},  // R8 offset miss
    '{3'd4, 32'h6000_0000, 32'h6000_0000, 1'b1}   // R3 R4 both control bits
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d, output logic req);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    req = rst_req_o;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic sys_pulse();
    @(negedge clk);
    sys_rst_i = 1'b1;
    @(negedge clk);
    sys_rst_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic        q;
    logic [31:0] r;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 rd_data in reset", rd_data, 32'h0);
    check("R10 req in reset", {31'h0, rst_req_o}, 32'h0);
    rst = 1'b0;
    rd(3'd4, r);
    check("R10 R11 register after power-up", r, 32'h0);
    @(negedge clk);
    check("R11 idle rd_data zero", rd_data, 32'h0);

    sys_pulse();
    rd(3'd4, r);
    check("R6 first reset loads power-on", r, 32'h8000_0000);

    foreach (VEC[i]) begin
      wr(VEC[i].a, VEC[i].d, q);
      check($sformatf("R4/R5/R8 req vector %0d", i), {31'h0, q}, {31'h0, VEC[i].req});
      rd(VEC[i].a, r);
      check($sformatf("R8 miss read vector %0d", i), r, VEC[i].a[2] ? VEC[i].exp : 32'h0);
      check($sformatf("R4 pulse ended vector %0d", i), {31'h0, rst_req_o}, 32'h0);
      rd(3'd4, r);
      check($sformatf("R1/R2/R3 value vector %0d", i), r, VEC[i].exp);
    end

    sys_pulse();
    rd(3'd4, r);
    check("R4 R6 reset after soft power-on", r, 32'h8000_0000);

    wr(3'd4, 32'h2000_0000, q);
    check("R5 soft external request", {31'h0, q}, 32'h1);
    sys_pulse();
    rd(3'd4, r);
    check("R5 R6 later reset keeps value", r, 32'hA000_0000);

    wr(3'd4, 32'h8000_0000, q);
    @(negedge clk);
    addr = 3'd4; wr_data = 32'h2000_0000; wr_en = 1'b1; sys_rst_i = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; sys_rst_i = 1'b0;
    check("R9 collision no request", {31'h0, rst_req_o}, 32'h0);
    rd(3'd4, r);
    check("R9 collision write dropped", r, 32'h0);

    for (int k = 0; k < 20; k++) sys_pulse();
    rd(3'd4, r);
    check("R7 saturated counter no wrap", r, 32'h0);

    wr(3'd4, 32'h4000_0000, q);
    check("R4 soft power-on request", {31'h0, q}, 32'h1);
    rd(3'd4, r);
    check("R3 R4 control bit stored", r, 32'h4000_0000);
    sys_pulse();
    rd(3'd4, r);
    check("R4 R7 counter zeroed from saturation", r, 32'h8000_0000);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule